// File: doc/BRIEF.md
# Sequential Triangular-Number Engine

This block takes an 8-bit value n and produces the total n + (n-1) + ... + 2 + 1. A small datapath holds a down-counter loaded with n and an accumulator cleared to zero. It also contains one adder, a zero detector on the counter, and an output gate. A four-state controller runs the arithmetic. It reacts to a rising edge on a push-button start line, loads the operands, and then repeats add-and-decrement once per clock until the zero detector reports that the counter is empty. It then raises a completion flag.

The controller drives the load and step controls into the datapath and reads back the zero status. The accumulator is as wide as the input and wraps modulo 2^WIDTH. The result port reads zero except while the completion flag is high. The flag and the result stay put until start is released and pressed again.

Top module: `sum_engine`

## Requirements
- R1: While reset is held and after it is released with start low, `done_o` is 0 and `sum_o` is 0.
- R2: After a computation, `sum_o` equals n(n+1)/2 reduced modulo 256, where n is the value on `n_i` at the load edge.
- R3: `done_o` first reads 1 after the (n+3)-th rising clock edge, counting the edge that samples the rising edge of `start_i` as the first.
- R4: For n = 0 the loop body never runs: `done_o` reads 1 after the third edge and `sum_o` is 0.
- R5: Whenever `done_o` is 0, `sum_o` is 0.
- R6: While `done_o` is 1 and no new rising edge of `start_i` occurs, whether start is held high or released, `done_o` stays 1 and `sum_o` holds its value.
- R7: A rising edge of `start_i` sampled while the block is idle or finished starts a new computation, and `done_o` reads 0 after that same clock edge.
- R8: Rising edges of `start_i` while a computation is in progress are ignored: the result and its latency are unchanged.
- R9: `n_i` is sampled only on the clock edge right after the edge that captures the start edge, and later changes to `n_i` do not affect the result.
- R10: Totals beyond 255 wrap (n = 23 gives 20, n = 255 gives 128).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to `clk_i` |
| start_i | input | 1 | Start button level; its rising edge starts a computation |
| n_i | input | 8 | Upper bound n of the sum |
| sum_o | output | 8 | Gated result, valid while `done_o` is 1 |
| done_o | output | 1 | Result-ready flag |

## Verification
The assertions rely on two assumptions about the environment. First, `start_i` is synchronous to the clock. Second, reset deassertion is aligned to the clock. With both in place, the start edge detector sees every press as exactly one rising edge.

The stimulus changes `start_i` and `n_i` only on falling clock edges. It keeps `n_i` steady across the load edge before overwriting it with an unrelated value.

Stimulus that tests R8 pulses start mid-loop only for values of n large enough that the pulse lands inside the loop. That way the assertion on ignored presses is exercised on real loop cycles.

// File: rtl/sum_engine_pkg.sv
package sum_engine_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_LOOP = 2'd2,
    ST_DONE = 2'd3
  } eng_state_e;

endpackage

// File: rtl/sum_start_edge.sv
module sum_start_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic rise_o
);

  logic start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start_i;
    end
  end

  assign rise_o = start_i & ~start_q;

endmodule

// File: rtl/sum_datapath.sv
module sum_datapath #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             show_i,
  input  logic [WIDTH-1:0] n_i,
  output logic             zero_o,
  output logic [WIDTH-1:0] sum_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] acc_q, acc_d;
  logic             reg_en;

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    reg_en = load_i | step_i;
    if (load_i) begin
      cnt_d = n_i;
      acc_d = '0;
    end else if (step_i) begin
      cnt_d = cnt_q - ONE;
      acc_d = acc_q + cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (reg_en) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  assign zero_o = (cnt_q == '0);
  assign sum_o  = show_i ? acc_q : '0;

  // R2: the controller never steps an empty counter
  p_no_step_at_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !zero_o);

  // R9: load and step are never requested together
  p_load_step_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i));

endmodule

// File: rtl/sum_ctrl.sv
module sum_ctrl
  import sum_engine_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_rise_i,
  input  logic zero_i,
  output logic load_o,
  output logic step_o,
  output logic done_o
);

  eng_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_rise_i) state_d = ST_LOAD;
      end
      ST_LOAD: begin
        load_o  = 1'b1;
        state_d = ST_LOOP;
      end
      ST_LOOP: begin
        if (zero_i) begin
          state_d = ST_DONE;
        end else begin
          step_o = 1'b1;
        end
      end
      ST_DONE: begin
        done_o = 1'b1;
        if (start_rise_i) state_d = ST_LOAD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // R4: an empty counter during the loop finishes the job next cycle
  p_zero_ends_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOP && zero_i) |=> done_o);

  // R8: a press during the loop does not leave the loop
  p_busy_ignores_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOP && start_rise_i && !zero_i) |=> (state_q == ST_LOOP));

  // R6: finished state persists without a fresh press
  p_done_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_rise_i) |=> done_o);

  // R7: a fresh press while finished restarts with a load
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_rise_i) |=> (!done_o && load_o));

endmodule

// File: rtl/sum_engine.sv
module sum_engine #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] n_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             done_o
);

  logic start_rise;
  logic load_en;
  logic step_en;
  logic cnt_zero;

  sum_start_edge i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .rise_o  (start_rise)
  );

  sum_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_rise_i (start_rise),
    .zero_i       (cnt_zero),
    .load_o       (load_en),
    .step_o       (step_en),
    .done_o       (done_o)
  );

  sum_datapath #(
    .WIDTH (WIDTH)
  ) i_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_en),
    .step_i (step_en),
    .show_i (done_o),
    .n_i    (n_i),
    .zero_o (cnt_zero),
    .sum_o  (sum_o)
  );

  // R5: the result port is dark until the flag is up
  p_sum_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (sum_o == '0));

  // R6: result holds while finished and no fresh press arrives
  p_sum_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_rise) |=> $stable(sum_o));

endmodule

// File: tb/test_sum_engine.sv
`timescale 1ns/1ps
module test_sum_engine;

  typedef struct {
    logic [7:0] exp_sum;
    int         start_cyc;
    int         n;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] n_val = 8'd0;
  logic [7:0] sum;
  logic       done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic done_prev = 1'b0;
  exp_item_t sb_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sum_engine i_sum_engine (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .n_i     (n_val),
    .sum_o   (sum),
    .done_o  (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // monitor: gate check every cycle, scoreboard compare on flag rise
  always @(negedge clk) begin
    if (rst_n) begin
      if (!done) check(sum == 8'd0, "R5 gated output", sum, 0);
      if (done && !done_prev) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R8 unexpected completion", 1, 0);
        end else begin
          exp_item_t it;
          it = sb_q.pop_front();
          check(sum == it.exp_sum, "R2/R10 sum value", sum, it.exp_sum);
          check((cyc - it.start_cyc) == it.n + 3, "R3/R4 latency",
                cyc - it.start_cyc, it.n + 3);
        end
      end
    end
    done_prev <= done;
  end

  // driver: one computation; hold keeps start high to test R6, glitch tests R8
  task automatic run(input int n, input bit hold, input bit glitch);
    exp_item_t it;
    logic [7:0] kept;
    @(negedge clk);
    n_val = n[7:0];
    start = 1'b1;
    it.exp_sum   = 8'((n * (n + 1)) / 2);
    it.start_cyc = cyc;
    it.n         = n;
    sb_q.push_back(it);
    @(negedge clk);
    check(done == 1'b0, "R7 flag drops after press", done, 0);
    if (!hold) start = 1'b0;
    @(negedge clk);
    n_val = ~n[7:0] ^ 8'h5A; // R9: later changes must not matter
    if (glitch) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk);
    kept = sum;
    repeat (4) @(negedge clk);
    check(done == 1'b1, "R6 flag holds", done, 1);
    check(sum == kept, "R6 result holds", sum, kept);
    if (hold) begin
      start = 1'b0;
      repeat (3) @(negedge clk);
      check(done == 1'b1, "R6 flag holds after release", done, 1);
      check(sum == kept, "R6 result holds after release", sum, kept);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 reset flag", done, 0);
    check(sum == 8'd0, "R1 reset sum", sum, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 idle flag", done, 0);
    check(sum == 8'd0, "R1 idle sum", sum, 0);
    run(5, 1'b0, 1'b0);      // R2
    run(0, 1'b0, 1'b0);      // R4
    run(1, 1'b0, 1'b0);      // R2
    run(10, 1'b1, 1'b0);     // R6 held start
    run(22, 1'b0, 1'b1);     // R8 mid-loop press
    run(23, 1'b0, 1'b0);     // R10 wrap
    run(255, 1'b0, 1'b1);    // R10 wrap, R8
    run(7, 1'b1, 1'b0);      // R7 restart from finished
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule